// File: doc/BRIEF.md
# Random Number Generator Command and Status Controller

This block fronts a true random number generator on a simple 32-bit register bus. Software selects an output length, writes a command to generate or to seed, and then either polls status or waits for an interrupt. A generation run of fixed length fills eight 32-bit output words, or only the lower four in the short mode, and then flags random-ready. The entropy bit arrives on an input port, and a shift-and-feedback mixing register stands in for a real deterministic generator.

After reset the block is unseeded and seeds itself once. Later seeding happens on command, or by itself once a programmed number of 16-byte units has been served. A generate command that arrives while the block is busy is held and runs once the block goes idle. A no-operation command issued during generation aborts it. Interrupt flags are cleared by writing ones, and the interrupt line combines them with per-source enables and a global enable.

Top module: `trng_ctrl`

## Requirements
- R1: Reading offset 0xF0 returns 0x000046BC. Out of reset the status register (offset 0x04) shows bit 31 (reseeding) set and bit 9 (seeded) clear.
- R2: After reset the block seeds itself for SEED_CYCLES cycles. It then sets status bit 9, clears bit 31, and sets bit 1 (seed-done) of the flag register at offset 0x14.
- R3: Writing 1 to bits [1:0] of offset 0x00 while idle starts generation, with status bit 30 set while it runs. Random-ready (flag bit 0) is set exactly GEN_LONG (1024) cycles after the command edge when bit 3 of offset 0x08 is 1, and GEN_LONG/2 cycles after when that bit is 0.
- R4: Output words sit at offsets 0x20 to 0x3C and are updated when random-ready is set. In the short mode, words 4 to 7 (0x30 to 0x3C) read zero. Each run yields fresh word values.
- R5: Writing a 1 to a bit of offset 0x14 clears that flag. If hardware sets the same flag in the same cycle, the set takes priority.
- R6: irq_o is high exactly when bit 31 of offset 0x10 is set and some flag is set whose enable bit (bit 0 for random-ready, bit 1 for seed-done) is also set.
- R7: A generate command written while the block is seeding or generating is held and starts on the cycle after the block returns to idle.
- R8: A no-operation write (0 in bits [1:0] of offset 0x00) during generation stops it at once, clears status bit 30, drops any held command, and never sets random-ready.
- R9: Offset 0x60 holds a count N. When N is nonzero, each completed run counts 1 unit in short mode and 2 units in long mode. When the running total reaches N, the block starts a reseed at the end of that run and restarts the total. Writing offset 0x60 also restarts the total.
- R10: Writing 2 to bits [1:0] of offset 0x00 runs a SEED_CYCLES seed with status bit 31 set, keeps bit 9 set, and sets seed-done at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the access |
| ent_i | input | 1 | Raw entropy bit |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a software write-one-to-clear of random-ready and the hardware setting that flag when a run ends. The bench counts cycles from the generate command and places the clearing write on exactly the completion edge, then expects the flag to read back as set. A second collision is a generate command that lands while a seed is still running. The bench checks that the command is held, and that its total latency equals the seed length plus one idle cycle plus the generation length.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam logic [1:0] CMD_NOP  = 2'd0;
  localparam logic [1:0] CMD_RAND = 2'd1;
  localparam logic [1:0] CMD_SEED = 2'd2;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_MODE  = 8'h08;
  localparam logic [7:0] OFF_IE    = 8'h10;
  localparam logic [7:0] OFF_FLAG  = 8'h14;
  localparam logic [7:0] OFF_WORD0 = 8'h20;
  localparam logic [7:0] OFF_AUTO  = 8'h60;
  localparam logic [7:0] OFF_VER   = 8'hF0;
  localparam logic [31:0] VERSION_CODE = 32'h0000_46BC;

  typedef enum logic [1:0] {S_IDLE, S_GEN, S_SEED} seq_state_e;
endpackage

// File: rtl/trng_seq.sv
module trng_seq
  import trng_pkg::*;
#(
  parameter int GEN_LONG    = 1024,
  parameter int SEED_CYCLES = 64,
  parameter int REQ_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [1:0]       cmd_i,
  input  logic             mode_long_i,
  input  logic [REQ_W-1:0] auto_n_i,
  input  logic             cnt_clr_i,
  output logic             gen_busy_o,
  output logic             seed_busy_o,
  output logic             seeded_o,
  output logic             mode_long_o,
  output logic             gen_done_o,
  output logic             seed_done_o
);
  localparam int CNT_W = $clog2(GEN_LONG > SEED_CYCLES ? GEN_LONG : SEED_CYCLES);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(GEN_LONG - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(GEN_LONG / 2 - 1);
  localparam logic [CNT_W-1:0] SEED_LAST  = CNT_W'(SEED_CYCLES - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       pend_q;
  logic             mode_q, seeded_q;
  logic [REQ_W:0]   served_q, served_nxt;
  logic             is_nop, abort, quota_hit;

  always_comb begin
    is_nop      = (cmd_i != CMD_RAND) && (cmd_i != CMD_SEED);
    abort       = cmd_wr_i && is_nop && (state_q == S_GEN);
    gen_done_o  = (state_q == S_GEN) && !abort &&
                  (cnt_q == (mode_q ? LONG_LAST : SHORT_LAST));
    seed_done_o = (state_q == S_SEED) && (cnt_q == SEED_LAST);
    served_nxt  = served_q + (mode_q ? (REQ_W+1)'(2) : (REQ_W+1)'(1));
    quota_hit   = (auto_n_i != '0) && (served_nxt >= {1'b0, auto_n_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_SEED;
      cnt_q    <= '0;
      pend_q   <= CMD_NOP;
      mode_q   <= 1'b0;
      seeded_q <= 1'b0;
      served_q <= '0;
    end else begin
      if (cnt_clr_i) served_q <= '0;
      unique case (state_q)
        S_IDLE: begin
          if (cmd_wr_i && !is_nop) begin
            state_q <= (cmd_i == CMD_RAND) ? S_GEN : S_SEED;
            cnt_q   <= '0;
            mode_q  <= mode_long_i;
            pend_q  <= CMD_NOP;
          end else if (cmd_wr_i) begin
            pend_q <= CMD_NOP;
          end else if (pend_q != CMD_NOP) begin
            state_q <= (pend_q == CMD_RAND) ? S_GEN : S_SEED;
            cnt_q   <= '0;
            mode_q  <= mode_long_i;
            pend_q  <= CMD_NOP;
          end
        end
        S_GEN: begin
          if (abort) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            pend_q  <= CMD_NOP;
          end else begin
            if (cmd_wr_i) pend_q <= cmd_i;
            if (gen_done_o) begin
              cnt_q <= '0;
              if (quota_hit) begin
                state_q  <= S_SEED;
                served_q <= '0;
              end else begin
                state_q <= S_IDLE;
                if (auto_n_i != '0 && !cnt_clr_i) served_q <= served_nxt;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin // S_SEED
          if (cmd_wr_i) pend_q <= is_nop ? CMD_NOP : cmd_i;
          if (seed_done_o) begin
            seeded_q <= 1'b1;
            state_q  <= S_IDLE;
            cnt_q    <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign gen_busy_o  = (state_q == S_GEN);
  assign seed_busy_o = (state_q == S_SEED);
  assign seeded_o    = seeded_q;
  assign mode_long_o = mode_q;

  a_r2_seeded_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seeded_o |=> seeded_o);
  a_r7_rand_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i == CMD_RAND && state_q != S_IDLE && !abort) |=> pend_q == CMD_RAND);
  a_r8_abort_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!gen_busy_o && !gen_done_o));
  a_r9_quota_reseed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_done_o && quota_hit) |=> (seed_busy_o && served_q == '0));
endmodule

// File: rtl/trng_mix.sv
module trng_mix #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ent_i,
  input  logic                      gen_i,
  input  logic                      seed_i,
  input  logic                      gen_done_i,
  input  logic                      mode_long_i,
  output logic [N_WORDS*WORD_W-1:0] words_o
);
  localparam int POOL_W = N_WORDS * WORD_W;

  logic [POOL_W-1:0] pool_q;
  logic [WORD_W-1:0] key_q;
  logic              fb;

  assign fb = pool_q[POOL_W-1] ^ pool_q[POOL_W-3] ^ pool_q[POOL_W-6] ^
              pool_q[POOL_W-11] ^ ent_i ^ key_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pool_q <= POOL_W'(1);
      key_q  <= '0;
    end else begin
      if (gen_i || seed_i) pool_q <= {pool_q[POOL_W-2:0], fb};
      if (seed_i)     key_q <= {key_q[WORD_W-2:0], key_q[WORD_W-1] ^ ent_i};
      else if (gen_i) key_q <= {key_q[0], key_q[WORD_W-1:1]};
    end
  end

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (gen_done_i)
        word_q <= (mode_long_i || i < N_WORDS / 2) ? pool_q[i*WORD_W +: WORD_W] : '0;
    end
    assign words_o[i*WORD_W +: WORD_W] = word_q;
    if (i >= N_WORDS / 2) begin : g_upper
      a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gen_done_i && !mode_long_i) |=> word_q == '0);
    end
  end
endmodule

// File: rtl/trng_ctrl.sv
module trng_ctrl
  import trng_pkg::*;
#(
  parameter int GEN_LONG    = 1024,
  parameter int SEED_CYCLES = 64,
  parameter int REQ_W       = 16,
  parameter int N_WORDS     = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        ent_i,
  output logic        irq_o
);
  localparam int WORD_W = 32;
  localparam logic [7:0] WORD_END = OFF_WORD0 + 8'(4 * N_WORDS);

  logic             wr, rd;
  logic             mode_q, ie_glbl_q;
  logic [1:0]       ie_q, flag_q;
  logic [REQ_W-1:0] auto_q;
  logic             gen_busy, seed_busy, seeded, mode_run, gen_done, seed_done;
  logic [N_WORDS*WORD_W-1:0] words;
  logic [31:0]      rmux;
  logic             unused_bits;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;
  assign unused_bits = ^{wdata_i, addr_i[1:0]};

  trng_seq #(.GEN_LONG(GEN_LONG), .SEED_CYCLES(SEED_CYCLES), .REQ_W(REQ_W)) u_seq (
    .clk_i, .rst_ni,
    .cmd_wr_i    (wr && addr_i == OFF_CTRL),
    .cmd_i       (wdata_i[1:0]),
    .mode_long_i (mode_q),
    .auto_n_i    (auto_q),
    .cnt_clr_i   (wr && addr_i == OFF_AUTO),
    .gen_busy_o  (gen_busy),
    .seed_busy_o (seed_busy),
    .seeded_o    (seeded),
    .mode_long_o (mode_run),
    .gen_done_o  (gen_done),
    .seed_done_o (seed_done)
  );

  trng_mix #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_mix (
    .clk_i, .rst_ni, .ent_i,
    .gen_i       (gen_busy),
    .seed_i      (seed_busy),
    .gen_done_i  (gen_done),
    .mode_long_i (mode_run),
    .words_o     (words)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= 1'b0;
      ie_glbl_q <= 1'b0;
      ie_q      <= '0;
      flag_q    <= '0;
      auto_q    <= '0;
    end else begin
      if (wr && addr_i == OFF_MODE) mode_q <= wdata_i[3];
      if (wr && addr_i == OFF_IE) begin
        ie_glbl_q <= wdata_i[31];
        ie_q      <= wdata_i[1:0];
      end
      if (wr && addr_i == OFF_AUTO) auto_q <= wdata_i[REQ_W-1:0];
      // hardware set beats software clear
      flag_q <= ((wr && addr_i == OFF_FLAG) ? (flag_q & ~wdata_i[1:0]) : flag_q) |
                {seed_done, gen_done};
    end
  end

  always_comb begin
    rmux = '0;
    if (addr_i >= OFF_WORD0 && addr_i < WORD_END)
      rmux = words[32'(addr_i[7:2] - OFF_WORD0[7:2]) * WORD_W +: WORD_W];
    else
      unique case (addr_i)
        OFF_STAT: rmux = {seed_busy, gen_busy, 20'd0, seeded, 9'd0};
        OFF_MODE: rmux = {28'd0, mode_q, 3'd0};
        OFF_IE:   rmux = {ie_glbl_q, 29'd0, ie_q};
        OFF_FLAG: rmux = {30'd0, flag_q};
        OFF_AUTO: rmux = 32'(auto_q);
        OFF_VER:  rmux = VERSION_CODE;
        default:  rmux = '0;
      endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rmux;
  end

  assign irq_o = ie_glbl_q && |(ie_q & flag_q);

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_done |=> flag_q[0]);
  a_r2_seed_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_done |=> flag_q[1]);
  a_r6_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_glbl_q |-> !irq_o);
endmodule

// File: tb/trng_ctrl_tb.sv
`timescale 1ns/1ps
module trng_ctrl_tb;
  localparam int GEN_LONG = 1024;
  localparam int SEED_CYCLES = 64;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, ent;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  logic [15:0] lfsr = 16'hACE1;
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end
  assign ent = lfsr[0];

  trng_ctrl u_dut (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
                   .wdata_i(wdata), .rdata_o(rdata), .ent_i(ent), .irq_o(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); d = rdata; req = 0;
  endtask

  task automatic wait_irq(output int t);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    t = cyc;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, w0a, w7a;
    int t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state and version
    rd(8'h04, d);
    chk(d[31] == 1 && d[9] == 0, "R1 reset status", d, 32'h8000_0000);
    rd(8'hF0, d);
    chk(d == 32'h46BC, "R1 version", d, 32'h46BC);
    // R2: initial self seed
    repeat (SEED_CYCLES) @(negedge clk);
    rd(8'h04, d);
    chk(d == 32'h0000_0200, "R2 seeded status", d, 32'h0000_0200);
    rd(8'h14, d);
    chk(d == 32'h2, "R2 seed-done flag", d, 32'h2);
    // R6: enable gating
    wr(8'h10, 32'h8000_0001);
    @(negedge clk);
    chk(irq == 0, "R6 seed-done not enabled", {31'd0, irq}, 0);
    wr(8'h10, 32'h8000_0003);
    @(negedge clk);
    chk(irq == 1, "R6 seed-done enabled", {31'd0, irq}, 1);
    wr(8'h10, 32'h0000_0003);
    @(negedge clk);
    chk(irq == 0, "R6 global off", {31'd0, irq}, 0);
    wr(8'h10, 32'h8000_0003);
    wr(8'h14, 32'h2);  // R5 clear
    @(negedge clk);
    chk(irq == 0, "R5 W1C clears seed-done", {31'd0, irq}, 0);
    rd(8'h14, d);
    chk(d == 0, "R5 flag reg empty", d, 0);
    wr(8'h10, 32'h8000_0001);
    // R3: long latency
    wr(8'h08, 32'h8);
    wr(8'h00, 32'h1); t0 = cyc;
    wait_irq(t1);
    chk(t1 - t0 == GEN_LONG, "R3 long latency", t1 - t0, GEN_LONG);
    rd(8'h20, w0a);
    rd(8'h3C, w7a);
    chk(w7a != 0, "R4 long upper word filled", w7a, 1);
    // R3/R4: short mode
    wr(8'h14, 32'h3);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h1); t0 = cyc;
    wait_irq(t1);
    chk(t1 - t0 == GEN_LONG / 2, "R3 short latency", t1 - t0, GEN_LONG / 2);
    for (int i = 4; i < 8; i++) begin
      rd(8'(8'h20 + 4 * i), d);
      chk(d == 0, "R4 short upper word zero", d, 0);
    end
    rd(8'h20, d);
    chk(d != w0a, "R4 fresh word0", d, ~w0a);
    // R5: clear lands on completion edge; set wins
    wr(8'h14, 32'h3);
    wr(8'h00, 32'h1);
    repeat (GEN_LONG / 2 - 2) @(negedge clk);
    wr(8'h14, 32'h1);
    rd(8'h14, d);
    chk(d[0] == 1, "R5 set wins over clear", d, 1);
    wr(8'h14, 32'h1);
    rd(8'h14, d);
    chk(d[0] == 0, "R5 later clear", d, 0);
    // R3 busy flag, R8 abort
    wr(8'h00, 32'h1);
    rd(8'h04, d);
    chk(d[30] == 1, "R3 generating flag", d, 32'h4000_0200);
    repeat (100) @(negedge clk);
    wr(8'h00, 32'h0);
    rd(8'h04, d);
    chk(d[30] == 0, "R8 abort clears generating", d, 32'h200);
    repeat (GEN_LONG) @(negedge clk);
    rd(8'h14, d);
    chk(d[0] == 0, "R8 no ready after abort", d, 0);
    // R10 seed command, R7 held RAND
    wr(8'h00, 32'h2);
    wr(8'h00, 32'h1); t0 = cyc;
    rd(8'h04, d);
    chk(d[31] == 1 && d[9] == 1, "R10 reseeding while seeded", d, 32'h8000_0200);
    wait_irq(t1);
    chk(t1 - t0 == SEED_CYCLES + GEN_LONG / 2 - 1, "R7 held rand latency",
        t1 - t0, SEED_CYCLES + GEN_LONG / 2 - 1);
    rd(8'h14, d);
    chk(d == 32'h3, "R10 seed-done and ready", d, 3);
    // R9 auto reseed, short mode N=3
    wr(8'h60, 32'd3);
    for (int k = 1; k <= 3; k++) begin
      wr(8'h14, 32'h3);
      wr(8'h00, 32'h1);
      wait_irq(t1);
      rd(8'h04, d);
      chk(d[31] == (k == 3), "R9 reseed on quota (short)", d[31], k == 3);
    end
    wr(8'h14, 32'h2);
    repeat (SEED_CYCLES + 4) @(negedge clk);
    rd(8'h14, d);
    chk(d[1] == 1, "R9 auto reseed done flag", d, 3);
    // R9 long mode counts two units
    wr(8'h60, 32'd2);
    wr(8'h08, 32'h8);
    wr(8'h14, 32'h3);
    wr(8'h00, 32'h1);
    wait_irq(t1);
    rd(8'h04, d);
    chk(d[31] == 1, "R9 reseed on quota (long)", d, 32'h8000_0200);
    finish_run();
  end
endmodule